// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes 16-bit control words from a three-wire serial link (bit clock, data, latch strobe) and turns them into parallel register outputs for the volume and control logic around it. Data bits are taken on each rising edge of the bit clock, most significant bit first, into a shift register. A rising edge on the latch strobe marks the end of a word. Only the latch frames a word, so the bit clock may keep running between words.

On a latch the two lowest bits of the word pick the destination and the upper fourteen bits become its new contents. There are three destinations: left volume, right volume and a control word. For each accepted write the block gives a one-cycle pulse on that destination's update strobe. The serial lines are asynchronous to the system clock. Each line passes through a multi-stage synchroniser, and edges are detected in the system clock domain. The serial clock therefore has to be several times slower than the system clock.

Top module: `serctl_port`

## Requirements
- R1: A word is 16 bits sent most significant bit first. Word bits [1:0] are the destination code and word bits [15:2] are the 14-bit payload, which appears as output bits [13:0].
- R2: Destination code 00 loads the payload into `vol_left_o`.
- R3: Destination code 10 (bit1=1, bit0=0) loads the payload into `vol_right_o`.
- R4: Destination code 01 (bit1=0, bit0=1) loads the payload into `ctrl_o`.
- R5: Destination code 11 is reserved. A word carrying it changes no output and produces no update strobe.
- R6: A data bit is captured on the rising edge of the bit clock. Data that changes while the bit clock is low is taken at the next rising edge.
- R7: When more than 16 bits arrive before a latch edge, only the last 16 are used and the earlier ones are discarded.
- R8: Bit clock activity with the latch held low never writes a register and never raises an update strobe.
- R9: Each accepted write raises exactly one of `wr_left_o`, `wr_right_o`, `wr_ctrl_o` for exactly one system clock cycle. The new value is visible on the same cycle.
- R10: After reset both volume outputs are all ones, `ctrl_o` is zero and no strobe is high.
- R11: `soft_mute_o` follows bit 6 of the control payload, which is word bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Latch strobe; rising edge ends a word |
| vol_left_o | output | 14 | Left volume register |
| vol_right_o | output | 14 | Right volume register |
| ctrl_o | output | 14 | Control register |
| soft_mute_o | output | 1 | Soft-mute enable (control bit 6) |
| wr_left_o | output | 1 | One-cycle strobe on left volume write |
| wr_right_o | output | 1 | One-cycle strobe on right volume write |
| wr_ctrl_o | output | 1 | One-cycle strobe on control write |

## Verification
Directed words go to each of the four destination codes. They use payloads of all zeros, all ones and alternating bits, which separate a swapped code decode from a bit-order or payload-offset error. Control words that set and then clear bit 6 show that the mute output tracks the right field. Random words, each with a random number of junk bits sent ahead of it, show that only the last sixteen bits count. Between some words the bit clock keeps running with the latch low, which tells framing by latch apart from framing by bit count.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LEFT  = 2'b00,
    SEL_CTRL  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_RSVD  = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              slat_s,
  output logic [WORD_W-1:0] word_o,
  output logic              latch_evt_o
);
  logic              sclk_q, slat_q;
  logic [WORD_W-1:0] shift_q;
  logic              bit_evt;

  function automatic logic f_rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  assign bit_evt     = f_rise(sclk_s, sclk_q);
  assign latch_evt_o = f_rise(slat_s, slat_q);
  assign word_o      = shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      slat_q  <= 1'b0;
      shift_q <= '0;
    end else begin
      sclk_q <= sclk_s;
      slat_q <= slat_s;
      if (bit_evt) shift_q <= {shift_q[WORD_W-2:0], sdat_s};
    end
  end

  // R6: the newest bit enters at the bottom on a bit clock rise
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> shift_q[0] == $past(sdat_s));
  // R8: no bit clock rise, no shift
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_evt |=> $stable(shift_q));
endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank
  import serctl_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WORD_W-1:0]        word_i,
  input  logic                     latch_evt_i,
  output logic [WORD_W-ADDR_W-1:0] vol_left_o,
  output logic [WORD_W-ADDR_W-1:0] vol_right_o,
  output logic [WORD_W-ADDR_W-1:0] ctrl_o,
  output logic                     wr_left_o,
  output logic                     wr_right_o,
  output logic                     wr_ctrl_o
);
  localparam int PAY_W = WORD_W - ADDR_W;

  function automatic reg_sel_e f_sel(input logic [WORD_W-1:0] w);
    return reg_sel_e'(w[ADDR_W-1:0]);
  endfunction

  function automatic logic [PAY_W-1:0] f_payload(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:ADDR_W];
  endfunction

  reg_sel_e         sel;
  logic [PAY_W-1:0] payload;
  logic             hit_left, hit_right, hit_ctrl, hit_rsvd;

  assign sel       = f_sel(word_i);
  assign payload   = f_payload(word_i);
  assign hit_left  = latch_evt_i && (sel == SEL_LEFT);
  assign hit_right = latch_evt_i && (sel == SEL_RIGHT);
  assign hit_ctrl  = latch_evt_i && (sel == SEL_CTRL);
  assign hit_rsvd  = latch_evt_i && (sel == SEL_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_left_o  <= '1;
      vol_right_o <= '1;
      ctrl_o      <= '0;
      wr_left_o   <= 1'b0;
      wr_right_o  <= 1'b0;
      wr_ctrl_o   <= 1'b0;
    end else begin
      wr_left_o  <= hit_left;
      wr_right_o <= hit_right;
      wr_ctrl_o  <= hit_ctrl;
      if (hit_left)  vol_left_o  <= payload;
      if (hit_right) vol_right_o <= payload;
      if (hit_ctrl)  ctrl_o      <= payload;
    end
  end

  p_left_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_left |=> wr_left_o && vol_left_o == $past(payload));
  p_right_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_right |=> wr_right_o && vol_right_o == $past(payload));
  p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |=> wr_ctrl_o && ctrl_o == $past(payload));
  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rsvd |=> !wr_left_o && !wr_right_o && !wr_ctrl_o &&
                 $stable(vol_left_o) && $stable(vol_right_o) && $stable(ctrl_o));
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_left_o, wr_right_o, wr_ctrl_o}));
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_left_o || wr_right_o || wr_ctrl_o) |=> !(wr_left_o || wr_right_o || wr_ctrl_o));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt_i |=> $stable(vol_left_o) && $stable(vol_right_o) && $stable(ctrl_o));
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MUTE_BIT    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk_i,
  input  logic                     ser_dat_i,
  input  logic                     ser_lat_i,
  output logic [WORD_W-ADDR_W-1:0] vol_left_o,
  output logic [WORD_W-ADDR_W-1:0] vol_right_o,
  output logic [WORD_W-ADDR_W-1:0] ctrl_o,
  output logic                     soft_mute_o,
  output logic                     wr_left_o,
  output logic                     wr_right_o,
  output logic                     wr_ctrl_o
);
  localparam int LINES = 3;

  logic [LINES-1:0]  line_s;
  logic [WORD_W-1:0] word;
  logic              latch_evt;

  serctl_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_lat_i, ser_dat_i, ser_clk_i}),
    .sync_o  (line_s)
  );

  serctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s      (line_s[0]),
    .sdat_s      (line_s[1]),
    .slat_s      (line_s[2]),
    .word_o      (word),
    .latch_evt_o (latch_evt)
  );

  serctl_regbank #(.WORD_W(WORD_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_i      (word),
    .latch_evt_i (latch_evt),
    .vol_left_o  (vol_left_o),
    .vol_right_o (vol_right_o),
    .ctrl_o      (ctrl_o),
    .wr_left_o   (wr_left_o),
    .wr_right_o  (wr_right_o),
    .wr_ctrl_o   (wr_ctrl_o)
  );

  assign soft_mute_o = ctrl_o[MUTE_BIT];

  // R11: mute changes only together with a control write
  p_mute_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_o |-> $stable(soft_mute_o) || $past(!rst_n));
endmodule

// File: tb/serctl_port_test.sv
module serctl_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic [13:0] vol_l, vol_r, ctrl;
  logic mute, wl, wr, wc;

  int tests = 0, fails = 0;
  int cnt_l = 0, cnt_r = 0, cnt_c = 0;
  logic [13:0] exp_l, exp_r, exp_c;

  always #5 clk = ~clk;

  serctl_port uut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_lat_i(ser_lat), .vol_left_o(vol_l), .vol_right_o(vol_r),
    .ctrl_o(ctrl), .soft_mute_o(mute), .wr_left_o(wl), .wr_right_o(wr),
    .wr_ctrl_o(wc)
  );

  always @(posedge clk) begin
    if (wl) cnt_l <= cnt_l + 1;
    if (wr) cnt_r <= cnt_r + 1;
    if (wc) cnt_c <= cnt_c + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input logic [15:0] w);
    return w[1:0];
  endfunction

  // bench model of a write: returns which strobe should fire (0 none, 1 L, 2 R, 3 C)
  function automatic int apply(input logic [15:0] w);
    logic [13:0] p;
    p = w >> 2;
    case (code_of(w))
      2'b00: begin exp_l = p; return 1; end
      2'b10: begin exp_r = p; return 2; end
      2'b01: begin exp_c = p; return 3; end
      default: return 0;
    endcase
  endfunction

  task automatic half(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_clk = 1'b0; ser_dat = b; half(4);
    ser_clk = 1'b1; half(4);
  endtask

  task automatic send_word(input logic [15:0] w, input int junk);
    for (int j = 0; j < junk; j++) send_bit(1'($urandom));
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    ser_clk = 1'b0; half(2);
    ser_lat = 1'b1; half(4);
    ser_lat = 1'b0; half(10);
  endtask

  task automatic check_all(input string req, input int who);
    chk(req, "vol_left", int'(vol_l), int'(exp_l));
    chk(req, "vol_right", int'(vol_r), int'(exp_r));
    chk(req, "ctrl", int'(ctrl), int'(exp_c));
    chk("R11", "soft_mute", int'(mute), int'(exp_c[6]));
    chk("R9", "left strobes", cnt_l, who == 1 ? 1 : 0);
    chk("R9", "right strobes", cnt_r, who == 2 ? 1 : 0);
    chk("R9", "ctrl strobes", cnt_c, who == 3 ? 1 : 0);
  endtask

  task automatic xact(input logic [15:0] w, input int junk, input string req);
    int who;
    cnt_l = 0; cnt_r = 0; cnt_c = 0;
    who = apply(w);
    send_word(w, junk);
    check_all(req, who);
  endtask

  initial begin
    #1_500_000ns;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_l = '1; exp_r = '1; exp_c = '0;
    half(5);
    // R10: reset state
    chk("R10", "vol_left", int'(vol_l), 16'h3fff);
    chk("R10", "vol_right", int'(vol_r), 16'h3fff);
    chk("R10", "ctrl", int'(ctrl), 0);
    chk("R10", "strobes", int'({wl, wr, wc}), 0);
    rst_n = 1'b1;
    half(5);

    xact(16'h0000, 0, "R2 R1 zeros left");
    xact(16'hFFFE, 0, "R3 ones right");
    xact(16'hAAA9, 0, "R4 R1 pattern ctrl");
    xact({14'h0040, 2'b01}, 0, "R4 R11 mute set");
    xact({14'h0000, 2'b01}, 0, "R11 mute clear");
    xact({14'h1234, 2'b11}, 0, "R5 reserved");
    xact({14'h2B5C, 2'b00}, 5, "R7 junk then left");
    xact({14'h0155, 2'b10}, 2, "R6 R1 right alternating");

    // R8: free-running bit clock, latch low
    cnt_l = 0; cnt_r = 0; cnt_c = 0;
    for (int k = 0; k < 20; k++) send_bit(1'($urandom));
    ser_clk = 1'b0; half(10);
    check_all("R8 idle clocks", 0);

    for (int t = 0; t < 50; t++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (t % 7 == 3) begin
        cnt_l = 0; cnt_r = 0; cnt_c = 0;
        for (int k = 0; k < int'($urandom_range(1, 9)); k++) send_bit(1'($urandom));
        ser_clk = 1'b0; half(6);
        check_all("R8 gap", 0);
      end
      xact(w, int'($urandom_range(0, 6)), "R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule